// File: doc/BRIEF.md
# Deterministic-Latency Receive Release Buffer

This block sits on the receive side between a multi-lane serial link core and user logic. Each cycle in which the core flags its stream word as valid, the block writes that word into a dual-clock FIFO. The write side runs on the core clock and the read side runs on the user clock. Each lane also sends a one-cycle flag when its sync control word arrives, and the block keeps a sticky record of these flags per lane.

Read-out is held back until the block is told to release. A periodic timing pulse (sysref) starts a programmable down-counter, and every new rising edge restarts it. When the counter runs out, the block checks two things: every lane must have seen its control word, and the FIFO must hold at least a prefill margin of entries. If both hold, the block raises a sticky in-sync flag and streams the buffered words out in order from then on. If either fails, it waits for the next pulse.

The delay is set to the round-trip path latency plus the prefill margin. With that setting the end-to-end latency is fixed, and the margin absorbs transmit gaps and lane skew. The block also reports FIFO occupancy and an empty flag on the read side, and it passes a reset indication to user logic.

Top module: `det_rx_buffer`

## Requirements
- R1: A word is written into the FIFO only in a core-clock cycle with `in_valid_i` high. Cycles with `in_valid_i` low leave the occupancy unchanged.
- R2: `fifo_pfull_o` reports the number of stored entries as seen from the user clock, and `fifo_empty_o` is high exactly when that number is zero.
- R3: Count the first user-clock edge that samples `sysref_i` high as edge 1. If no later rising edge intervenes, `in_sync_o` rises at edge `RELEASE_DLY`+3. A later rising edge of `sysref_i` restarts this count from itself.
- R4: When the delay expires, `in_sync_o` rises only if every bit of `lane_cw_i` has been seen high since reset.
- R5: When the delay expires, `in_sync_o` rises only if the occupancy is at least `PREFILL`. If it is lower, the block waits for the next sysref edge.
- R6: Once high, `in_sync_o` stays high until reset, whatever happens on `sysref_i`.
- R7: `out_valid_o` stays low while `in_sync_o` is low. After that, the FIFO is read in every user cycle in which it is not empty. Each word appears on `out_data_o` with `out_valid_o` high one cycle after its read, in write order.
- R8: A one-cycle pulse on a bit of `lane_cw_i` is remembered until reset, independently of the other lanes.
- R9: `rst_o` is high, without any clock, whenever `link_rst_i` is high or `rst_n` is low.
- R10: Reset clears `in_sync_o`, the per-lane records and the FIFO (empty high, occupancy zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_core | input | 1 | Write-side clock from the link core |
| clk_user | input | 1 | Read-side user clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| link_rst_i | input | 1 | Active-high receive reset from the link core |
| rst_o | output | 1 | Active-high reset indication to user logic |
| sysref_i | input | 1 | Periodic timing pulse, asynchronous |
| lane_cw_i | input | LANES | Per-lane control-word-seen pulses, core clock |
| in_data_i | input | LANES*128 | Stream data from the link core |
| in_valid_i | input | 1 | Qualifies `in_data_i` |
| out_data_o | output | LANES*128 | Released stream data |
| out_valid_o | output | 1 | Qualifies `out_data_o` |
| in_sync_o | output | 1 | Sticky release flag |
| fifo_empty_o | output | 1 | FIFO empty, user clock |
| fifo_pfull_o | output | ADDR_W+1 | FIFO occupancy, user clock |

## Verification
The bench builds the block with two lanes, a 32-entry FIFO, a release delay of 20 and a prefill margin of 13. The short delay lets one run trigger several sysref cycles. These cover a release blocked by a missing lane, a release blocked by a low fill, a restart of the countdown by a second pulse, and a release after a reset that erased the lane records. Driving both clocks from one source makes the release edge exact, so the bench can check it to the cycle. A 16-word fill brings the prefill threshold and an ordered drain of the whole buffer within reach.

// File: rtl/drb_pkg.sv
package drb_pkg;

  localparam int PTR_MAX = 16;

  typedef enum logic [1:0] {
    RL_WAIT   = 2'd0,
    RL_COUNT  = 2'd1,
    RL_LOCKED = 2'd2
  } rel_state_e;

  function automatic logic [PTR_MAX-1:0] gray_to_bin(input logic [PTR_MAX-1:0] g);
    logic [PTR_MAX-1:0] b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX-2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/drb_rst_sync.sv
module drb_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/drb_sync.sv
module drb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d_i;
      hold_q <= meta_q;
    end
  end

  assign q_o = hold_q;
endmodule

// File: rtl/drb_afifo.sv
module drb_afifo #(
  parameter int DW = 256,
  parameter int AW = 5
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          wfull,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          rempty,
  output logic [AW:0]   rocc
);
  import drb_pkg::*;

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int PAD   = PTR_MAX - PW;

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0] rgray_w, rbin_w, wocc;
  logic [PTR_MAX-1:0] rbin_w_ext;
  logic wr_ok;

  drb_sync #(.W(PW)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d_i(rgray_q), .q_o(rgray_w)
  );

  always_comb begin
    rbin_w_ext = gray_to_bin({{PAD{1'b0}}, rgray_w});
    rbin_w     = rbin_w_ext[PW-1:0];
    wocc       = wbin_q - rbin_w;
    wfull      = wocc[AW];
    wr_ok      = wr_en & ~wfull;
    wbin_d     = wr_ok ? wbin_q + 1'b1 : wbin_q;
    wgray_d    = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin_q[AW-1:0]] <= wdata;
  end

  // read domain
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic [PW-1:0] wgray_r, wbin_r;
  logic [PTR_MAX-1:0] wbin_r_ext;
  logic rd_ok;
  logic [DW-1:0] rdata_q;
  logic rvalid_q;

  drb_sync #(.W(PW)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d_i(wgray_q), .q_o(wgray_r)
  );

  always_comb begin
    wbin_r_ext = gray_to_bin({{PAD{1'b0}}, wgray_r});
    wbin_r     = wbin_r_ext[PW-1:0];
    rocc       = wbin_r - rbin_q;
    rempty     = (rocc == '0);
    rd_ok      = rd_en & ~rempty;
    rbin_d     = rd_ok ? rbin_q + 1'b1 : rbin_q;
    rgray_d    = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rbin_q   <= rbin_d;
      rgray_q  <= rgray_d;
      rvalid_q <= rd_ok;
    end
  end

  always_ff @(posedge rclk) begin
    if (rd_ok) rdata_q <= mem[rbin_q[AW-1:0]];
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  AST_OCC_BOUND: assert property (@(posedge rclk) disable iff (!rrst_n)
    rocc <= PW'(DEPTH)); // R2
endmodule

// File: rtl/drb_release.sv
module drb_release #(
  parameter int           LANES       = 2,
  parameter logic [7:0]   RELEASE_DLY = 8'd185,
  parameter int           PREFILL     = 13,
  parameter int           OW          = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sysref_i,
  input  logic [LANES-1:0] lanes_i,
  input  logic [OW-1:0]    occ_i,
  output logic             in_sync_o
);
  import drb_pkg::*;

  logic       sref_s, sref_d_q, sref_rise;
  logic       release_ok;
  rel_state_e state_q, state_d;
  logic [7:0] cnt_q, cnt_d;

  drb_sync #(.W(1)) u_sref_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sysref_i), .q_o(sref_s)
  );

  always_comb begin
    sref_rise  = sref_s & ~sref_d_q;
    release_ok = (&lanes_i) && (occ_i >= OW'(PREFILL));
    state_d    = state_q;
    cnt_d      = cnt_q;
    case (state_q)
      RL_WAIT: begin
        if (sref_rise) begin
          state_d = RL_COUNT;
          cnt_d   = RELEASE_DLY - 8'd1;
        end
      end
      RL_COUNT: begin
        if (sref_rise) begin
          cnt_d = RELEASE_DLY - 8'd1;
        end else if (cnt_q == 8'd0) begin
          state_d = release_ok ? RL_LOCKED : RL_WAIT;
        end else begin
          cnt_d = cnt_q - 8'd1;
        end
      end
      RL_LOCKED: state_d = RL_LOCKED;
      default:   state_d = RL_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RL_WAIT;
      cnt_q    <= 8'd0;
      sref_d_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      sref_d_q <= sref_s;
    end
  end

  assign in_sync_o = (state_q == RL_LOCKED);

  AST_SYNC_NEEDS_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync_o) |-> $past(&lanes_i)); // R4
  AST_SYNC_NEEDS_PREFILL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_sync_o) |-> $past(occ_i >= OW'(PREFILL))); // R5
endmodule

// File: rtl/det_rx_buffer.sv
module det_rx_buffer #(
  parameter int         LANES       = 2,
  parameter int         ADDR_W      = 5,
  parameter logic [7:0] RELEASE_DLY = 8'd185,
  parameter int         PREFILL     = 13
) (
  input  logic                   clk_core,
  input  logic                   clk_user,
  input  logic                   rst_n,
  input  logic                   link_rst_i,
  output logic                   rst_o,
  input  logic                   sysref_i,
  input  logic [LANES-1:0]       lane_cw_i,
  input  logic [LANES*128-1:0]   in_data_i,
  input  logic                   in_valid_i,
  output logic [LANES*128-1:0]   out_data_o,
  output logic                   out_valid_o,
  output logic                   in_sync_o,
  output logic                   fifo_empty_o,
  output logic [ADDR_W:0]        fifo_pfull_o
);
  localparam int DW = LANES * 128;
  localparam int OW = ADDR_W + 1;

  logic arst_n, rst_core_n, rst_user_n;
  logic wfull_unused;

  assign arst_n = rst_n & ~link_rst_i;
  assign rst_o  = ~rst_n | link_rst_i;

  drb_rst_sync u_rst_core (.clk(clk_core), .arst_n(arst_n), .srst_n(rst_core_n));
  drb_rst_sync u_rst_user (.clk(clk_user), .arst_n(arst_n), .srst_n(rst_user_n));

  // sticky per-lane control-word record, core domain
  logic [LANES-1:0] seen_q, seen_d, seen_u;

  always_comb seen_d = seen_q | lane_cw_i;

  always_ff @(posedge clk_core or negedge rst_core_n) begin
    if (!rst_core_n) seen_q <= '0;
    else             seen_q <= seen_d;
  end

  drb_sync #(.W(LANES)) u_lane_sync (
    .clk(clk_user), .rst_n(rst_user_n), .d_i(seen_q), .q_o(seen_u)
  );

  logic [OW-1:0] occ;
  logic          sync_w;

  drb_afifo #(.DW(DW), .AW(ADDR_W)) u_fifo (
    .wclk(clk_core), .wrst_n(rst_core_n), .wr_en(in_valid_i), .wdata(in_data_i),
    .wfull(wfull_unused),
    .rclk(clk_user), .rrst_n(rst_user_n), .rd_en(sync_w), .rdata(out_data_o),
    .rvalid(out_valid_o), .rempty(fifo_empty_o), .rocc(occ)
  );

  drb_release #(.LANES(LANES), .RELEASE_DLY(RELEASE_DLY), .PREFILL(PREFILL), .OW(OW)) u_rel (
    .clk(clk_user), .rst_n(rst_user_n), .sysref_i(sysref_i), .lanes_i(seen_u),
    .occ_i(occ), .in_sync_o(sync_w)
  );

  assign in_sync_o    = sync_w;
  assign fifo_pfull_o = occ;

  AST_VALID_NEEDS_SYNC: assert property (@(posedge clk_user) disable iff (!rst_user_n)
    out_valid_o |-> in_sync_o); // R7
endmodule

// File: tb/det_rx_buffer_tb.sv
module det_rx_buffer_tb;
  localparam int         LANES = 2;
  localparam int         AW    = 5;
  localparam logic [7:0] RBD   = 8'd20;
  localparam int         PRE   = 13;
  localparam int         NV    = 20;

  // bit 32 = valid, bits 31:0 = word tag
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 32'hC0DE0001}, {1'b1, 32'hC0DE0002}, {1'b0, 32'hDEAD0003}, {1'b1, 32'hC0DE0004},
    {1'b1, 32'hC0DE0005}, {1'b1, 32'hC0DE0006}, {1'b1, 32'hC0DE0007}, {1'b0, 32'hDEAD0008},
    {1'b1, 32'h5A5A0009}, {1'b1, 32'h5A5A000A}, {1'b1, 32'h5A5A000B}, {1'b0, 32'hDEAD000C},
    {1'b1, 32'h0F0F000D}, {1'b1, 32'h0F0F000E}, {1'b1, 32'h0F0F000F}, {1'b0, 32'hDEAD0010},
    {1'b1, 32'h12340011}, {1'b1, 32'h12340012}, {1'b1, 32'h12340013}, {1'b1, 32'h12340014}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n = 1'b0, link_rst_i = 1'b0, sysref_i = 1'b0, in_valid_i = 1'b0;
  logic [LANES-1:0]     lane_cw_i = '0;
  logic [LANES*128-1:0] in_data_i = '0;
  logic                 rst_o, out_valid_o, in_sync_o, fifo_empty_o;
  logic [LANES*128-1:0] out_data_o;
  logic [AW:0]          fifo_pfull_o;

  det_rx_buffer #(.LANES(LANES), .ADDR_W(AW), .RELEASE_DLY(RBD), .PREFILL(PRE)) u_dut (
    .clk_core(clk), .clk_user(clk), .rst_n(rst_n), .link_rst_i(link_rst_i), .rst_o(rst_o),
    .sysref_i(sysref_i), .lane_cw_i(lane_cw_i), .in_data_i(in_data_i), .in_valid_i(in_valid_i),
    .out_data_o(out_data_o), .out_valid_o(out_valid_o), .in_sync_o(in_sync_o),
    .fifo_empty_o(fifo_empty_o), .fifo_pfull_o(fifo_pfull_o)
  );

  int checks = 0;
  int errors = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_range(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) begin
      in_valid_i = VEC[i][32];
      in_data_i  = {(LANES*4){VEC[i][31:0]}};
      tick(1);
    end
    in_valid_i = 1'b0;
  endtask

  task automatic pulse_sysref();
    sysref_i = 1'b1;
    tick(2);
    sysref_i = 1'b0;
  endtask

  task automatic pulse_lanes(input logic [LANES-1:0] m);
    lane_cw_i = m;
    tick(1);
    lane_cw_i = '0;
    tick(5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int got;
    int nvalid;
    logic [31:0] exp_tags [NV];
    nvalid = 0;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) begin
        exp_tags[nvalid] = VEC[i][31:0];
        nvalid++;
      end
    end

    // reset state
    tick(3);
    check("R10 in_sync after reset", 32'(in_sync_o), 32'd0);
    check("R10 out_valid after reset", 32'(out_valid_o), 32'd0);
    check("R10 empty after reset", 32'(fifo_empty_o), 32'd1);
    check("R10 occupancy after reset", 32'(fifo_pfull_o), 32'd0);
    check("R9 rst_o with rst_n low", 32'(rst_o), 32'd1);
    rst_n = 1'b1;
    tick(4);
    check("R9 rst_o idle", 32'(rst_o), 32'd0);
    link_rst_i = 1'b1;
    #1;
    check("R9 rst_o follows link reset", 32'(rst_o), 32'd1);
    tick(1);
    link_rst_i = 1'b0;
    tick(4);

    // phase A: only lane 0 seen, full table written
    pulse_lanes(2'b01);
    push_range(0, NV-1);
    tick(6);
    check("R1 occupancy counts valid beats only", 32'(fifo_pfull_o), 32'(nvalid));
    check("R2 not empty", 32'(fifo_empty_o), 32'd0);
    pulse_sysref();
    tick(int'(RBD) + 8);
    check("R4 no sync with a lane missing", 32'(in_sync_o), 32'd0);
    check("R7 no output before sync", 32'(out_valid_o), 32'd0);
    check("R7 nothing read before sync", 32'(fifo_pfull_o), 32'(nvalid));

    // phase B: lane 1 arrives, restart by second sysref edge
    pulse_lanes(2'b10);
    pulse_sysref();
    tick(8);
    pulse_sysref();
    tick(int'(RBD));
    check("R3 in_sync low one edge early after restart", 32'(in_sync_o), 32'd0);
    tick(1);
    check("R3 R8 in_sync rises on time", 32'(in_sync_o), 32'd1);
    check("R7 valid one cycle after first read", 32'(out_valid_o), 32'd0);
    got = 0;
    for (int i = 0; i < 40; i++) begin
      tick(1);
      if (out_valid_o) begin
        if (got < nvalid)
          check("R7 output word order", out_data_o[31:0], exp_tags[got]);
        check("R7 word replicated across lanes", 32'(out_data_o == {(LANES*4){out_data_o[31:0]}}), 32'd1);
        got++;
      end
    end
    check("R7 all words drained", 32'(got), 32'(nvalid));
    check("R2 empty after drain", 32'(fifo_empty_o), 32'd1);
    check("R2 occupancy zero after drain", 32'(fifo_pfull_o), 32'd0);

    // phase C: in_sync sticky
    pulse_sysref();
    tick(int'(RBD) + 8);
    check("R6 in_sync holds after later sysref", 32'(in_sync_o), 32'd1);

    // phase D: reset clears lane records
    rst_n = 1'b0;
    tick(2);
    check("R10 in_sync cleared by reset", 32'(in_sync_o), 32'd0);
    check("R10 occupancy cleared by reset", 32'(fifo_pfull_o), 32'd0);
    rst_n = 1'b1;
    tick(4);
    push_range(0, NV-1);
    tick(6);
    pulse_sysref();
    tick(int'(RBD) + 8);
    check("R10 lane records cleared by reset", 32'(in_sync_o), 32'd0);
    check("R1 occupancy after refill", 32'(fifo_pfull_o), 32'(nvalid));

    // phase E: prefill margin
    do_reset();
    pulse_lanes(2'b11);
    push_range(0, 7);
    tick(6);
    check("R1 partial fill occupancy", 32'(fifo_pfull_o), 32'd6);
    pulse_sysref();
    tick(int'(RBD) + 8);
    check("R5 no sync below prefill", 32'(in_sync_o), 32'd0);
    push_range(8, NV-1);
    tick(6);
    pulse_sysref();
    tick(int'(RBD) + 8);
    check("R5 sync once prefill reached", 32'(in_sync_o), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule